// File: doc/BRIEF.md
# Low-Power Mode and Reset Sequencer

This block decides, cycle by cycle, which clocks of a small microcontroller run and whether its oscillator is on. Software asks for a lighter or a deeper sleep by writing two control bits. The request takes effect once the current instruction completes. In the light sleep (idle) the CPU clock stops while the oscillator and peripheral clocks keep running. In the deep sleep (power-down) the oscillator itself is switched off.

Idle ends on any enabled pending interrupt or on the reset pin. Power-down ends in one of two ways. The first is the reset pin. The second is an external interrupt line that is enabled and set to level triggering: holding it low restarts the oscillator, and releasing it high completes the wake-up. In both cases the CPU clock stays gated until the oscillator has been stable for a fixed count. A reset is recognised only after the reset pin has stayed high for two machine cycles of a running oscillator. When reset arrives during idle, the core runs briefly before the reset is recognised, and internal RAM writes are blocked during that window. The block also tells the pad logic what each port should present while the core sleeps.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: `core_reset` rises after `rst_pin` has been high for RST_MC*CLKS_PER_MC consecutive clocks while the oscillator is on and `osc_stable` is high. A shorter pulse leaves it low. It falls on the first clock after `rst_pin` goes low.
- R2: After a write with `pcon_idle`=1 and `pcon_pd`=0, the next `instr_done` enters idle. In idle `cpu_clk_en`=0, while `periph_clk_en`=1 and `osc_en`=1.
- R3: In idle, `pca_clk_en` is 0 when `pca_idle_stop`=1 and 1 when it is 0. Outside the sleep modes `pca_clk_en` is 1.
- R4: In idle, `irq_pending`=1 returns the block to run (`cpu_clk_en`=1) on the next clock without asserting `core_reset`.
- R5: A write with `pcon_pd`=1 selects power-down even when `pcon_idle`=1. In power-down `osc_en`, `cpu_clk_en`, `periph_clk_en` and `pca_clk_en` are all 0.
- R6: In power-down the following do not wake the block: `irq_pending`, a low line configured edge-triggered (`xint_edge`=1), and a low line with `xint_en`=0.
- R7: A low, enabled, level-triggered line (`xint_edge`=0) in power-down sets `osc_en`=1 with `cpu_clk_en`=0. The CPU clock returns only when the line is high again and STAB_CYCLES clocks of `osc_stable` have been counted. `core_reset` stays 0.
- R8: `rst_pin` high in power-down sets `osc_en`=1. `core_reset` then follows the R1 count, and run resumes once the stability count has also expired.
- R9: When `rst_pin` rises in idle, from the next clock `cpu_clk_en`=1 and `ram_wr_block`=1. Both hold until the reset is recognised, after which `ram_wr_block` returns to 0.
- R10: Port selects are encoded as 0 = core drives, 1 = hold latch data, 2 = float, 3 = address. In run and in the idle reset window all three selects are 0. In idle, `p0_sel` is 2 with external code and 1 otherwise, and `p2_sel` is 3 with external code and 1 otherwise. In power-down, `p0_sel` is 2 with external code and 1 otherwise, and `p2_sel` is 1. In both sleeps `p13_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset of the sequencer, active low |
| rst_pin | input | 1 | Synchronised external reset pin, active high |
| osc_stable | input | 1 | Oscillator is running |
| pcon_wr | input | 1 | Write strobe for the sleep request bits |
| pcon_idle | input | 1 | Idle request bit |
| pcon_pd | input | 1 | Power-down request bit |
| instr_done | input | 1 | Current instruction has completed |
| irq_pending | input | 1 | Some enabled interrupt is pending |
| xint_n | input | NUM_XINT | External interrupt lines, active low |
| xint_en | input | NUM_XINT | External interrupt enables |
| xint_edge | input | NUM_XINT | 1 = edge-triggered, 0 = level-triggered |
| ext_code | input | 1 | Core fetches code from external memory |
| pca_idle_stop | input | 1 | Pause the counter array during idle |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pca_clk_en | output | 1 | Counter-array clock enable |
| osc_en | output | 1 | Oscillator enable |
| ram_wr_block | output | 1 | Inhibit internal RAM writes |
| core_reset | output | 1 | Recognised reset to the core |
| p0_sel | output | 2 | Port 0 pad select |
| p2_sel | output | 2 | Port 2 pad select |
| p13_sel | output | 2 | Ports 1 and 3 pad select |

## Verification
The reset pin is exercised with a pulse just short of the recognition count and with one that crosses it, which separates a correct count from an off-by-one. Power-down is approached with every wake source that must be ignored before the valid level-triggered line is used. That line is first released well after the oscillator is stable and then released before it is stable, which shows whether the exit waits for both conditions. Reset is also applied in idle and in power-down, which contrasts the idle execution window against the gated oscillator restart. External versus internal code and both counter-array settings are tried in idle to cover the pad selects and the clock enable.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_IDLE     = 3'd1,
    ST_IDLE_RST = 3'd2,
    ST_PD_OFF   = 3'd3,
    ST_PD_WAKE  = 3'd4,
    ST_PD_RST   = 3'd5
  } pwr_state_e;

  typedef enum logic [1:0] {
    PS_CORE  = 2'd0,
    PS_DATA  = 2'd1,
    PS_FLOAT = 2'd2,
    PS_ADDR  = 2'd3
  } port_sel_e;

  function automatic logic in_pd(input pwr_state_e s);
    return (s == ST_PD_OFF) || (s == ST_PD_WAKE) || (s == ST_PD_RST);
  endfunction

  function automatic logic core_runs(input pwr_state_e s);
    return (s == ST_RUN) || (s == ST_IDLE_RST);
  endfunction

  function automatic port_sel_e p0_sel_f(input pwr_state_e s, input logic ext);
    if (core_runs(s)) return PS_CORE;
    return ext ? PS_FLOAT : PS_DATA;
  endfunction

  function automatic port_sel_e p2_sel_f(input pwr_state_e s, input logic ext);
    if (core_runs(s)) return PS_CORE;
    if (s == ST_IDLE && ext) return PS_ADDR;
    return PS_DATA;
  endfunction

  function automatic port_sel_e p13_sel_f(input pwr_state_e s);
    return core_runs(s) ? PS_CORE : PS_DATA;
  endfunction

endpackage

// File: rtl/pwr_rst_qual.sv
module pwr_rst_qual #(
  parameter int LIM_CLKS = 24
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin,
  input  logic osc_run,
  output logic rst_seen
);
  localparam int CW = $clog2(LIM_CLKS + 1);

  logic [CW-1:0] cnt_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (!rst_pin) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (osc_run && !seen_q) begin
      if (cnt_q == CW'(LIM_CLKS - 1)) seen_q <= 1'b1;
      else                            cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign rst_seen = seen_q;

  // R1: recognition only ever happens while the pin is held
  a_r1_seen_needs_pin: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_seen) |-> $past(rst_pin) && $past(osc_run));
  // R1: qualification counter never runs past its limit
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!por_n)
    cnt_q <= CW'(LIM_CLKS - 1));
endmodule

// File: rtl/pwr_osc_stab.sv
module pwr_osc_stab #(
  parameter int STAB_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic osc_en,
  input  logic osc_stable,
  output logic stab_done
);
  localparam int CW = $clog2(STAB_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!osc_en) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (osc_stable && !done_q) begin
      if (cnt_q == CW'(STAB_CYCLES - 1)) done_q <= 1'b1;
      else                               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign stab_done = done_q;

  // R7: stability is only declared on a running, enabled oscillator
  a_r7_done_needs_osc: assert property (@(posedge clk) disable iff (!por_n)
    $rose(stab_done) |-> $past(osc_en) && $past(osc_stable));
endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int NUM_XINT = 2
) (
  input  logic [NUM_XINT-1:0] xint_n,
  input  logic [NUM_XINT-1:0] xint_en,
  input  logic [NUM_XINT-1:0] xint_edge,
  output logic                wake_lvl
);
  logic [NUM_XINT-1:0] hit;

  for (genvar i = 0; i < NUM_XINT; i++) begin : g_line
    assign hit[i] = xint_en[i] & ~xint_edge[i] & ~xint_n[i];
  end

  assign wake_lvl = |hit;
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int CLKS_PER_MC = 12,
  parameter int RST_MC      = 2,
  parameter int STAB_CYCLES = 16,
  parameter int NUM_XINT    = 2
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                rst_pin,
  input  logic                osc_stable,
  input  logic                pcon_wr,
  input  logic                pcon_idle,
  input  logic                pcon_pd,
  input  logic                instr_done,
  input  logic                irq_pending,
  input  logic [NUM_XINT-1:0] xint_n,
  input  logic [NUM_XINT-1:0] xint_en,
  input  logic [NUM_XINT-1:0] xint_edge,
  input  logic                ext_code,
  input  logic                pca_idle_stop,
  output logic                cpu_clk_en,
  output logic                periph_clk_en,
  output logic                pca_clk_en,
  output logic                osc_en,
  output logic                ram_wr_block,
  output logic                core_reset,
  output logic [1:0]          p0_sel,
  output logic [1:0]          p2_sel,
  output logic [1:0]          p13_sel
);
  localparam int RST_CLKS = RST_MC * CLKS_PER_MC;

  pwr_state_e state_q, state_d;
  logic       req_q, req_pd_q;
  logic       rst_seen, stab_done, wake_lvl, osc_run;

  // named internal events
  assign osc_en  = (state_q != ST_PD_OFF);
  assign osc_run = osc_en && osc_stable;

  pwr_rst_qual #(.LIM_CLKS(RST_CLKS)) u_rst_qual (
    .clk      (clk),
    .por_n    (por_n),
    .rst_pin  (rst_pin),
    .osc_run  (osc_run),
    .rst_seen (rst_seen)
  );

  pwr_osc_stab #(.STAB_CYCLES(STAB_CYCLES)) u_osc_stab (
    .clk        (clk),
    .por_n      (por_n),
    .osc_en     (osc_en),
    .osc_stable (osc_stable),
    .stab_done  (stab_done)
  );

  pwr_wake_detect #(.NUM_XINT(NUM_XINT)) u_wake (
    .xint_n    (xint_n),
    .xint_en   (xint_en),
    .xint_edge (xint_edge),
    .wake_lvl  (wake_lvl)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (!rst_seen && req_q && instr_done)
          state_d = req_pd_q ? ST_PD_OFF : ST_IDLE;
      end
      ST_IDLE: begin
        if (rst_pin)          state_d = ST_IDLE_RST;
        else if (irq_pending) state_d = ST_RUN;
      end
      ST_IDLE_RST: begin
        if (rst_seen || !rst_pin) state_d = ST_RUN;
      end
      ST_PD_OFF: begin
        if (rst_pin)       state_d = ST_PD_RST;
        else if (wake_lvl) state_d = ST_PD_WAKE;
      end
      ST_PD_WAKE: begin
        if (rst_pin)                     state_d = ST_PD_RST;
        else if (stab_done && !wake_lvl) state_d = ST_RUN;
      end
      ST_PD_RST: begin
        if (!rst_pin)                    state_d = ST_PD_OFF;
        else if (rst_seen && stab_done)  state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q  <= ST_RUN;
      req_q    <= 1'b0;
      req_pd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (rst_seen) begin
        req_q <= 1'b0;
      end else if (pcon_wr && (pcon_idle || pcon_pd)) begin
        req_q    <= 1'b1;
        req_pd_q <= pcon_pd;
      end else if (state_q == ST_RUN && state_d != ST_RUN) begin
        req_q <= 1'b0;
      end
    end
  end

  assign cpu_clk_en    = core_runs(state_q);
  assign periph_clk_en = !in_pd(state_q);
  assign pca_clk_en    = core_runs(state_q) || (state_q == ST_IDLE && !pca_idle_stop);
  assign ram_wr_block  = (state_q == ST_IDLE_RST);
  assign core_reset    = rst_seen;
  assign p0_sel        = p0_sel_f(state_q, ext_code);
  assign p2_sel        = p2_sel_f(state_q, ext_code);
  assign p13_sel       = p13_sel_f(state_q);

  // R7: leaving the wake state needs a stable oscillator and a released line
  a_r7_wake_exit: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_RUN && $past(state_q) == ST_PD_WAKE) |-> $past(stab_done) && !$past(wake_lvl));
  // R6: without reset or a level wake, power-down holds
  a_r6_pd_holds: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_PD_OFF && !rst_pin && !wake_lvl) |=> state_q == ST_PD_OFF);
  // R9: the RAM inhibit window only opens from idle on the reset pin
  a_r9_block_from_idle: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ram_wr_block) |-> $past(state_q == ST_IDLE) && $past(rst_pin));
  // R4: an interrupt in idle resumes the core without reset
  a_r4_idle_irq_exit: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_IDLE && irq_pending && !rst_pin) |=> cpu_clk_en && !core_reset);
endmodule

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MC = 12;
  localparam int RMC = 2;
  localparam int STAB = 16;
  localparam int NX = 2;
  localparam int RLIM = MC * RMC;
  localparam int OSC_LAG = 5;

  localparam int M_RUN = 0, M_IDLE = 1, M_IRST = 2, M_PDOFF = 3, M_PDWAKE = 4, M_PDRST = 5;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic rst_pin = 1'b0, osc_stable = 1'b0;
  logic pcon_wr = 1'b0, pcon_idle = 1'b0, pcon_pd = 1'b0, instr_done = 1'b0;
  logic irq_pending = 1'b0, ext_code = 1'b0, pca_idle_stop = 1'b0;
  logic [NX-1:0] xint_n = '1, xint_en = '0, xint_edge = '0;
  logic cpu_clk_en, periph_clk_en, pca_clk_en, osc_en, ram_wr_block, core_reset;
  logic [1:0] p0_sel, p2_sel, p13_sel;

  int errs = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_ctrl #(.CLKS_PER_MC(MC), .RST_MC(RMC), .STAB_CYCLES(STAB), .NUM_XINT(NX)) dut_i (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .osc_stable(osc_stable),
    .pcon_wr(pcon_wr), .pcon_idle(pcon_idle), .pcon_pd(pcon_pd), .instr_done(instr_done),
    .irq_pending(irq_pending), .xint_n(xint_n), .xint_en(xint_en), .xint_edge(xint_edge),
    .ext_code(ext_code), .pca_idle_stop(pca_idle_stop),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .pca_clk_en(pca_clk_en),
    .osc_en(osc_en), .ram_wr_block(ram_wr_block), .core_reset(core_reset),
    .p0_sel(p0_sel), .p2_sel(p2_sel), .p13_sel(p13_sel));

  // environment: oscillator becomes stable OSC_LAG clocks after enable
  int osc_age = 0;
  always @(posedge clk) begin
    if (!osc_en) begin
      osc_age <= 0;
      osc_stable <= 1'b0;
    end else if (osc_age < OSC_LAG) begin
      osc_age <= osc_age + 1;
    end else begin
      osc_stable <= 1'b1;
    end
  end

  // behavioural reference
  int m_mode = M_RUN, m_rc = 0, m_sc = 0;
  bit m_seen = 0, m_sdone = 0, m_req = 0, m_reqpd = 0;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_mode = M_RUN; m_rc = 0; m_sc = 0;
      m_seen = 0; m_sdone = 0; m_req = 0; m_reqpd = 0;
    end else begin
      bit on, ok, wake;
      int nm;
      on = (m_mode != M_PDOFF);
      ok = on && osc_stable;
      wake = 0;
      for (int i = 0; i < NX; i++)
        if (xint_en[i] && !xint_edge[i] && !xint_n[i]) wake = 1;
      nm = m_mode;
      case (m_mode)
        M_RUN:    if (!m_seen && m_req && instr_done) nm = m_reqpd ? M_PDOFF : M_IDLE;
        M_IDLE:   if (rst_pin) nm = M_IRST; else if (irq_pending) nm = M_RUN;
        M_IRST:   if (m_seen || !rst_pin) nm = M_RUN;
        M_PDOFF:  if (rst_pin) nm = M_PDRST; else if (wake) nm = M_PDWAKE;
        M_PDWAKE: if (rst_pin) nm = M_PDRST; else if (m_sdone && !wake) nm = M_RUN;
        default:  if (!rst_pin) nm = M_PDOFF; else if (m_seen && m_sdone) nm = M_RUN;
      endcase
      if (m_seen) m_req = 0;
      else if (pcon_wr && (pcon_idle || pcon_pd)) begin m_req = 1; m_reqpd = pcon_pd; end
      else if (m_mode == M_RUN && nm != M_RUN) m_req = 0;
      if (!rst_pin) begin m_rc = 0; m_seen = 0; end
      else if (ok && !m_seen) begin
        if (m_rc == RLIM - 1) m_seen = 1; else m_rc++;
      end
      if (!on) begin m_sc = 0; m_sdone = 0; end
      else if (osc_stable && !m_sdone) begin
        if (m_sc == STAB - 1) m_sdone = 1; else m_sc++;
      end
      m_mode = nm;
    end
  end

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (por_n) begin
      bit run_core, pd;
      int e0, e2;
      run_core = (m_mode == M_RUN || m_mode == M_IRST);
      pd = (m_mode >= M_PDOFF);
      cmp("R1", "core_reset", core_reset, m_seen);
      cmp("R2", "cpu_clk_en", cpu_clk_en, run_core);
      cmp("R2", "periph_clk_en", periph_clk_en, !pd);
      cmp("R3", "pca_clk_en", pca_clk_en, run_core || (m_mode == M_IDLE && !pca_idle_stop));
      cmp("R5", "osc_en", osc_en, m_mode != M_PDOFF);
      cmp("R9", "ram_wr_block", ram_wr_block, m_mode == M_IRST);
      e0 = run_core ? 0 : (ext_code ? 2 : 1);
      e2 = run_core ? 0 : ((m_mode == M_IDLE && ext_code) ? 3 : 1);
      cmp("R10", "p0_sel", p0_sel, e0);
      cmp("R10", "p2_sel", p2_sel, e2);
      cmp("R10", "p13_sel", p13_sel, run_core ? 0 : 1);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic request(input bit idle, input bit pd);
    pcon_wr = 1; pcon_idle = idle; pcon_pd = pd;
    wait_cyc(1);
    pcon_wr = 0; pcon_idle = 0; pcon_pd = 0; instr_done = 1;
    wait_cyc(1);
    instr_done = 0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    wait_cyc(3);
    por_n = 1;
    wait_cyc(2);
    cmp("R10", "reset p0_sel", p0_sel, 0);
    cmp("R2", "reset cpu_clk_en", cpu_clk_en, 1);
    cmp("R1", "reset core_reset", core_reset, 0);
    wait_cyc(10);

    // R1: short pulse then exact boundary
    rst_pin = 1; wait_cyc(RLIM - 2); rst_pin = 0;
    wait_cyc(3);
    cmp("R1", "short pulse core_reset", core_reset, 0);
    rst_pin = 1; wait_cyc(RLIM - 1);
    cmp("R1", "one clock early", core_reset, 0);
    wait_cyc(1);
    cmp("R1", "at count", core_reset, 1);
    rst_pin = 0; wait_cyc(1);
    cmp("R1", "release", core_reset, 0);

    // R2, R3, R10: idle with internal code, counter array running
    request(1, 0);
    cmp("R2", "idle cpu", cpu_clk_en, 0);
    cmp("R2", "idle periph", periph_clk_en, 1);
    cmp("R3", "idle pca run", pca_clk_en, 1);
    cmp("R10", "idle int p0", p0_sel, 1);
    pca_idle_stop = 1; ext_code = 1; wait_cyc(1);
    cmp("R3", "idle pca stop", pca_clk_en, 0);
    cmp("R10", "idle ext p0", p0_sel, 2);
    cmp("R10", "idle ext p2", p2_sel, 3);
    // R4
    irq_pending = 1; wait_cyc(1); irq_pending = 0;
    cmp("R4", "irq exit cpu", cpu_clk_en, 1);
    cmp("R4", "irq exit no reset", core_reset, 0);
    wait_cyc(3);

    // R5, R6: power-down with both bits, ignored wake sources
    request(1, 1);
    cmp("R5", "pd osc", osc_en, 0);
    cmp("R5", "pd periph", periph_clk_en, 0);
    cmp("R10", "pd ext p0", p0_sel, 2);
    cmp("R10", "pd p2", p2_sel, 1);
    irq_pending = 1; wait_cyc(4); irq_pending = 0;
    cmp("R6", "irq ignored", osc_en, 0);
    xint_en = 2'b01; xint_edge = 2'b01; xint_n = 2'b10; wait_cyc(4);
    cmp("R6", "edge line ignored", osc_en, 0);
    xint_en = 2'b00; xint_edge = 2'b00; wait_cyc(4);
    cmp("R6", "disabled line ignored", osc_en, 0);
    xint_n = 2'b11; ext_code = 0; wait_cyc(1);
    cmp("R10", "pd int p0", p0_sel, 1);

    // R7: level wake, held long
    xint_en = 2'b10; xint_n = 2'b01; wait_cyc(1);
    cmp("R7", "wake osc", osc_en, 1);
    cmp("R7", "wake cpu gated", cpu_clk_en, 0);
    wait_cyc(40);
    cmp("R7", "held low still gated", cpu_clk_en, 0);
    xint_n = 2'b11; wait_cyc(1);
    cmp("R7", "release resumes", cpu_clk_en, 1);
    cmp("R7", "no reset on wake", core_reset, 0);
    wait_cyc(3);

    // R7: released before the oscillator is stable
    request(0, 1);
    xint_n = 2'b01; wait_cyc(2); xint_n = 2'b11; wait_cyc(3);
    cmp("R7", "early release gated", cpu_clk_en, 0);
    wait_cyc(40);
    cmp("R7", "early release resumes", cpu_clk_en, 1);
    xint_en = 2'b00; wait_cyc(3);

    // R8: reset out of power-down
    request(0, 1);
    rst_pin = 1; wait_cyc(1);
    cmp("R8", "reset osc on", osc_en, 1);
    cmp("R8", "reset cpu gated", cpu_clk_en, 0);
    wait_cyc(RLIM + OSC_LAG + 10);
    cmp("R8", "reset recognised", core_reset, 1);
    cmp("R8", "run after reset", cpu_clk_en, 1);
    rst_pin = 0; wait_cyc(2);

    // R9: reset during idle
    pca_idle_stop = 0;
    request(1, 0);
    rst_pin = 1; wait_cyc(1);
    cmp("R9", "window cpu", cpu_clk_en, 1);
    cmp("R9", "window ram block", ram_wr_block, 1);
    cmp("R9", "window ports driven", p0_sel, 0);
    wait_cyc(RLIM + 2);
    cmp("R9", "after recognition block", ram_wr_block, 0);
    cmp("R9", "after recognition reset", core_reset, 1);
    rst_pin = 0; wait_cyc(3);

    summary();
    $finish;
  end
endmodule